// File: doc/BRIEF.md
# Microsecond Up-Counter with Sticky Overflow Interrupt

This block is an 8-bit up-counter for a small controller that runs from a 4 MHz system clock. A divide-by-four phase counter produces one advance per microsecond. Software controls the block through a write-only port with address, data and strobe signals. It can load a starting count, start and stop the counter with an active-low run bit, and acknowledge the overflow event.

When the count advances into its all-ones value, a sticky pending flag is set. The flag stays set through the wrap to zero and any later counting. Software clears it by writing a one to the acknowledge register. The flag cannot be read back. It appears only on the interrupt request output, which is the flag masked by an external interrupt-enable input. Choosing the loaded value sets the interval: a start value of P gives an interrupt after 255 - P microseconds, and a start value of FFh gives one every 256 microseconds.

Top module: `micro_timer`

## Requirements
- R1: After reset, and while reset is held, the counter is stopped with count 00h, the pending flag is clear and `irq` is low.
- R2: While running, the count advances once every 4 clock cycles. The phase counter is held at zero while stopped, so the first advance comes on the 4th rising edge after the edge that stores the run bit as 0.
- R3: A write to address 00C0h loads `wr_data[7:0]` into the count on that edge, whether the counter is running or stopped. If a load and an advance fall on the same edge, the loaded value is kept.
- R4: Bit 0 of the write to address 00C1h is stored as an active-low run bit: 0 runs and 1 stops. While it holds 1 the count does not change, except through a load.
- R5: An advance from FEh to FFh sets the pending flag on the same edge. Loading FFh does not set it. The next advance wraps the count to 00h, and counting carries on from there.
- R6: The pending flag stays set until a write to address 00C2h with `wr_data[0]` = 1 clears it on that edge. If a clear and a new FFh event fall on the same edge, the flag stays set.
- R7: `irq` is high exactly when the pending flag is set and `irq_en` is high, with no added register stage.
- R8: A write of 0 to bit 0 at 00C2h has no effect. Data bits 7 to 1 at 00C1h and 00C2h are ignored, and writes to any other address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz system clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq_en | input | 1 | Interrupt enable mask |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect on the rising edge where the strobe is sampled. The count first advances 4 edges after a run write, and every 4 edges after that. `irq` follows the flag in the same cycle, so an interrupt is due exactly 4 × (255 - P) edges after the run write, or 1024 edges when P is FFh. The bench drives inputs and samples `irq` on falling edges, and counts falling edges from the write's edge. It therefore compares each measured interval with the exact expected cycle count, not with a window. The same-edge races (load against advance, clear against set) are placed by counting three falling edges after the run write, so that the second write lands on the 4th edge.

// File: rtl/micro_timer_pkg.sv
package micro_timer_pkg;

    // Default geometry of the timer and its write port
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_DIV    = 4;

    // Which register a write strobe targets
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_PRESET = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_ACK    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/micro_timer_regs.sv
// Write decoder and control storage.
// Turns the write strobe into a load pulse with its value, an acknowledge
// pulse and the stored active-low run bit. Assumes one-cycle strobes;
// bits above bit 0 of control and acknowledge data are ignored.
module micro_timer_regs
    import micro_timer_pkg::*;
#(
    parameter int                ADDR_W      = DEF_ADDR_W,
    parameter int                DATA_W      = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] PRESET_ADDR = ADDR_W'('h00C0),
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'('h00C1),
    parameter logic [ADDR_W-1:0] ACK_ADDR    = ADDR_W'('h00C2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              load_stb,
    output logic [DATA_W-1:0] load_val,
    output logic              ack_stb,
    output logic              run_n
);

    reg_sel_e sel;

    // Classify the current write by address
    always_comb begin
        sel = SEL_NONE;
        if (wr_en) begin
            if (wr_addr == PRESET_ADDR)     sel = SEL_PRESET;
            else if (wr_addr == CTRL_ADDR)  sel = SEL_CTRL;
            else if (wr_addr == ACK_ADDR)   sel = SEL_ACK;
        end
    end

    // Pulses toward the counter and the flag
    always_comb begin
        load_stb = (sel == SEL_PRESET);
        load_val = wr_data;
        ack_stb  = (sel == SEL_ACK) && wr_data[0];
    end

    // Active-low run bit, level held until rewritten
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_n <= 1'b1;
        else if (sel == SEL_CTRL)
            run_n <= wr_data[0];
    end

endmodule

// File: rtl/micro_timer_prescale.sv
// Divide-by-DIV phase counter that yields one tick per count period.
// The phase is held at zero while stopped, so a restart always waits a
// full period. Assumes DIV >= 2.
module micro_timer_prescale
    import micro_timer_pkg::*;
#(
    parameter int DIV = DEF_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int                PS_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PS_W-1:0]   LAST = PS_W'(DIV - 1);

    logic [PS_W-1:0] phase;

    // Phase advance, cleared when stopped or at period end
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // Tick on the last phase of each period
    always_comb tick = run && (phase == LAST);

endmodule

// File: rtl/micro_timer_count.sv
// Loadable up-counter. A load wins over a tick on the same edge.
// Reports an all-ones event when a tick moves the count from
// all-ones minus one to all-ones.
module micro_timer_count
    import micro_timer_pkg::*;
#(
    parameter int CNT_W = DEF_DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             top_hit
);

    localparam logic [CNT_W-1:0] PRE_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

    // Count register: load first, then advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_stb)
            count <= load_val;
        else if (tick)
            count <= count + 1'b1;
    end

    // Event: this edge advances into all-ones
    always_comb top_hit = tick && !load_stb && (count == PRE_TOP);

endmodule

// File: rtl/micro_timer_flag.sv
// Sticky pending flag. Set has priority over acknowledge on one edge.
module micro_timer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic pend
);

    // Hold until acknowledged, unless set again on that edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end

endmodule

// File: rtl/micro_timer.sv
// Microsecond up-counter with sticky overflow interrupt.
// Assumes clk runs at DIV times the count rate and writes are
// single-cycle strobes. The pending flag leaves only through irq.
module micro_timer
    import micro_timer_pkg::*;
#(
    parameter int                ADDR_W      = DEF_ADDR_W,
    parameter int                DATA_W      = DEF_DATA_W,
    parameter int                DIV         = DEF_DIV,
    parameter logic [ADDR_W-1:0] PRESET_ADDR = ADDR_W'('h00C0),
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'('h00C1),
    parameter logic [ADDR_W-1:0] ACK_ADDR    = ADDR_W'('h00C2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    output logic              irq
);

    logic              load_stb;
    logic [DATA_W-1:0] load_val;
    logic              ack_stb;
    logic              run_n;
    logic              tick;
    logic [DATA_W-1:0] count;
    logic              top_hit;
    logic              pend;

    micro_timer_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PRESET_ADDR (PRESET_ADDR),
        .CTRL_ADDR   (CTRL_ADDR),
        .ACK_ADDR    (ACK_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_stb (load_stb),
        .load_val (load_val),
        .ack_stb  (ack_stb),
        .run_n    (run_n)
    );

    micro_timer_prescale #(.DIV(DIV)) u_pres (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!run_n),
        .tick  (tick)
    );

    micro_timer_count #(.CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_stb (load_stb),
        .load_val (load_val),
        .count    (count),
        .top_hit  (top_hit)
    );

    micro_timer_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (top_hit),
        .ack   (ack_stb),
        .pend  (pend)
    );

    // Masked level request
    always_comb irq = pend && irq_en;

endmodule

// File: rtl/micro_timer_chk.sv
// Property checker for micro_timer, attached by bind.
module micro_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_n,
    input logic             tick,
    input logic             load_stb,
    input logic [CNT_W-1:0] load_val,
    input logic             ack_stb,
    input logic [CNT_W-1:0] count,
    input logic             pend,
    input logic             irq_en,
    input logic             irq
);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                                // R2
    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (count == $past(load_val)));                       // R3
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_n && !load_stb) |=> $stable(count));                       // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_stb && (count == {CNT_W{1'b1}})) |=> (count == '0)); // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack_stb) |=> pend);                                   // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);                                              // R7

endmodule

bind micro_timer micro_timer_chk #(.CNT_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_n    (run_n),
    .tick     (tick),
    .load_stb (load_stb),
    .load_val (load_val),
    .ack_stb  (ack_stb),
    .count    (count),
    .pend     (pend),
    .irq_en   (irq_en),
    .irq      (irq)
);

// File: tb/micro_timer_test.sv
module micro_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 5;
    localparam logic [15:0] A_PRE  = 16'h00C0;
    localparam logic [15:0] A_CTL  = 16'h00C1;
    localparam logic [15:0] A_ACK  = 16'h00C2;

    // {preset value, expected cycles from run write to irq}
    localparam logic [7:0]  VEC_P [N_VEC] = '{8'hFE, 8'hF0, 8'h80, 8'h00, 8'hFF};
    localparam int          VEC_N [N_VEC] = '{4, 60, 508, 1020, 1024};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_en = 1'b1;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    micro_timer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_en  (irq_en),
        .irq     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Falling edges until irq rises, capped
    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        idle(1100);
        check("R1 stopped after reset", int'(irq), 0);

        // Vector table: load while stopped, start, measure interval
        for (int v = 0; v < N_VEC; v++) begin
            wr(A_CTL, 8'h01);
            wr(A_ACK, 8'h01);
            wr(A_PRE, VEC_P[v]);
            check("R5 load alone sets no flag", int'(irq), 0);
            wr(A_CTL, 8'h00);
            wait_irq(n);
            check("R2 R5 interval", n, VEC_N[v]);
        end

        // Sticky through wrap, mask, acknowledge
        idle(40);
        check("R5 R6 flag held after wrap", int'(irq), 1);
        irq_en = 1'b0; #1;
        check("R7 masked", int'(irq), 0);
        irq_en = 1'b1; #1;
        check("R7 unmasked", int'(irq), 1);
        wr(A_ACK, 8'h02);
        check("R8 ack bit0=0 ignored", int'(irq), 1);
        wr(A_ACK, 8'hFF);
        check("R6 ack clears", int'(irq), 0);

        // Stop holds count: F0 +5 ticks = F5, then 10 more ticks
        wr(A_CTL, 8'h01);
        wr(A_ACK, 8'h01);
        wr(A_PRE, 8'hF0);
        wr(A_CTL, 8'h00);
        idle(19);
        wr(A_CTL, 8'hFF);
        idle(100);
        check("R4 stopped no irq", int'(irq), 0);
        wr(A_CTL, 8'hFE);
        wait_irq(n);
        check("R4 resume from held count", n, 40);

        // Load while running
        wr(A_CTL, 8'h01);
        wr(A_ACK, 8'h01);
        wr(A_PRE, 8'h10);
        wr(A_CTL, 8'h00);
        wr(A_PRE, 8'hFD);
        wait_irq(n);
        check("R3 load while running", n, 7);

        // Load beats tick on the 4th edge
        wr(A_CTL, 8'h01);
        wr(A_ACK, 8'h01);
        wr(A_PRE, 8'hFA);
        wr(A_CTL, 8'h00);
        idle(3);
        wr(A_PRE, 8'hF0);
        wait_irq(n);
        check("R3 load wins over tick", n, 60);

        // Set beats acknowledge on the same edge
        wr(A_CTL, 8'h01);
        wr(A_ACK, 8'h01);
        wr(A_PRE, 8'hFE);
        wr(A_CTL, 8'h00);
        idle(3);
        wr(A_ACK, 8'h01);
        check("R6 set wins over ack", int'(irq), 1);
        wr(A_ACK, 8'h01);
        check("R6 later ack clears", int'(irq), 0);

        // Other address ignored
        wr(A_CTL, 8'h01);
        wr(A_PRE, 8'hFE);
        wr(16'h00C3, 8'h00);
        wr(16'h01C1, 8'h00);
        idle(50);
        check("R8 other address ignored", int'(irq), 0);

        // Reset clears a pending flag and stops the counter
        wr(A_CTL, 8'h00);
        idle(8);
        check("R5 flag before reset", int'(irq), 1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R1 reset clears flag", int'(irq), 0);
        idle(1100);
        check("R1 stopped after second reset", int'(irq), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule